// File: doc/BRIEF.md
# Programmable Card Bus Cycle Timer

This block turns one host request into the full strobe sequence of a single memory, attribute or I/O access on a PC Card style bus. The access runs in three phases in a fixed order: setup, command and recovery. During setup the address and the register-select line settle. During command exactly one strobe is active. During recovery the address is still held. When recovery ends, the block raises a one-cycle done pulse. On a read, it also returns the captured card data.

Each phase length comes from an 8-bit timing value, and two sets of these values are kept. The request picks which set times that access. In 8-bit host mode the block enables only the low card-enable. It steers the even or odd byte of the host word onto the low card data lane and puts read bytes back into their host lane.

Top module: `card_cycle_timer`

## Requirements
- R1: An access runs setup, then command, then recovery, and `busy` is high for exactly those cycles. `card_addr` equals the accepted address and does not change from the first setup cycle to the last recovery cycle.
- R2: A phase lasts (P × N + 1) clock cycles. N is bits [5:0] of the phase's timing value. P is 16 when bits [7:6] are not both zero, and 1 otherwise.
- R3: After reset, both timer sets hold setup 01h, command 06h and recovery 03h, which gives 2, 7 and 4 cycles.
- R4: The command phase lasts at least 2 cycles, even when the formula gives 1.
- R5: `req_timer_sel` picks the set used by that access (0 or 1). A register write (`cfg_phase` 0 setup, 1 command, 2 recovery) that lands during an access leaves that access unchanged and applies from the next one.
- R6: On writes, `card_d_oe` is high and `card_d_out` holds the write data for every busy cycle, from the first setup cycle on. On reads, `card_d_oe` stays low.
- R7: On reads, `rd_data` is loaded from `card_d_in` at the clock edge that ends the command phase, and it holds that value until the next read.
- R8: `req_kind` is encoded as 0 memory read (`card_oe_n`), 1 memory write (`card_we_n`), 2 I/O read (`card_iord_n`) and 3 I/O write (`card_iowr_n`). Only the matching strobe goes low, and at most one strobe is ever low.
- R9: With `host8` high, `card_ce2_n` stays high and `card_ce1_n` goes low. A write drives host byte [7:0] (even address) or [15:8] (odd address) on `card_d_out[7:0]`, with [15:8] at zero. A read returns `card_d_in[7:0]` in the host lane chosen by address bit 0, with the other lane at zero. With `host8` low, both enables go low and all 16 bits pass unchanged.
- R10: `done` pulses for one cycle in the cycle after the last recovery cycle. A request is taken only when `busy` is low, and `req_valid` while busy has no effect.
- R11: In reset and while idle, every strobe and card enable is high, `card_reg_n` is high, `card_d_oe` is low, and `done` is low. Reset also clears `rd_data` to zero.
- R12: During an access, `card_reg_n` is low for I/O accesses. For memory accesses it equals the inverse of `req_regspace`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host8 | input | 1 | 8-bit host mode select |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_set | input | SET_W | Timer set written |
| cfg_phase | input | 2 | Phase register written (0 setup, 1 command, 2 recovery) |
| cfg_wdata | input | 8 | Timing value |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | Access type |
| req_addr | input | AW | Card address |
| req_regspace | input | 1 | Attribute/register space for memory accesses |
| req_wdata | input | 16 | Host write word |
| req_timer_sel | input | SET_W | Timer set used by this access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 16 | Captured read data in host lanes |
| card_addr | output | AW | Card address bus |
| card_reg_n | output | 1 | Register-select line, low active |
| card_ce1_n | output | 1 | Low card enable |
| card_ce2_n | output | 1 | High card enable |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_d_out | output | 16 | Card write data |
| card_d_oe | output | 1 | Card data bus drive enable |
| card_d_in | input | 16 | Card read data |

## Verification
A request taken at a clock edge puts the bus into setup on the very next cycle. The command strobe follows S cycles later and recovery C cycles after that, so `done` falls due S+C+R cycles after the accepting edge. The monitor samples on falling edges and tags each busy cycle as setup, command or recovery by watching the strobes. It compares the three counts against the lengths queued by the driver when `done` shows up. `rd_data` is due from the edge that ends the command phase, and it is compared in the `done` cycle, by which time it must have settled. Write lanes, the enables and the register-select line are compared during the command cycles.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int TREG_W     = 8;
    localparam int NVAL_W     = 6;
    localparam int PRES_SHIFT = 4;
    localparam int LEN_W      = NVAL_W + PRES_SHIFT;
    localparam int BYTE_W     = 8;
    localparam int DATA_W     = 2 * BYTE_W;

    localparam logic [LEN_W-1:0]  LEN_ONE     = 1;
    localparam logic [LEN_W-1:0]  CMD_FLOOR   = 2;
    localparam logic [TREG_W-1:0] RST_SETUP   = 8'h01;
    localparam logic [TREG_W-1:0] RST_COMMAND = 8'h06;
    localparam logic [TREG_W-1:0] RST_RECOVER = 8'h03;

    typedef enum logic [1:0] {
        K_MEM_RD = 2'd0,
        K_MEM_WR = 2'd1,
        K_IO_RD  = 2'd2,
        K_IO_WR  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_REC   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [TREG_W-1:0] setup;
        logic [TREG_W-1:0] command;
        logic [TREG_W-1:0] recover;
    } timer_set_t;

    typedef struct packed {
        logic [LEN_W-1:0] setup_len;
        logic [LEN_W-1:0] cmd_len;
        logic [LEN_W-1:0] rec_len;
    } phase_lens_t;

    typedef struct packed {
        kind_e             kind;
        logic              regspace;
        logic              host8;
        logic [DATA_W-1:0] wdata;
    } req_info_t;

    function automatic logic [LEN_W-1:0] phase_len(
        input logic [TREG_W-1:0] v,
        input logic [LEN_W-1:0]  floor_len
    );
        logic [LEN_W-1:0] n;
        logic [LEN_W-1:0] len;
        n   = {{(LEN_W-NVAL_W){1'b0}}, v[NVAL_W-1:0]};
        len = (v[TREG_W-1:NVAL_W] != '0) ? ((n << PRES_SHIFT) + LEN_ONE) : (n + LEN_ONE);
        return (len < floor_len) ? floor_len : len;
    endfunction

    function automatic logic kind_is_write(input kind_e k);
        return (k == K_MEM_WR) || (k == K_IO_WR);
    endfunction

    function automatic logic kind_is_io(input kind_e k);
        return (k == K_IO_RD) || (k == K_IO_WR);
    endfunction

endpackage

// File: rtl/cbt_timing_regs.sv
module cbt_timing_regs
    import cbt_pkg::*;
#(
    parameter int NUM_SETS = 2,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SET_W-1:0]  cfg_set,
    input  logic [1:0]        cfg_phase,
    input  logic [TREG_W-1:0] cfg_wdata,
    input  logic [SET_W-1:0]  rd_set,
    output phase_lens_t       lens
);

    timer_set_t sets [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                sets[s] <= '{setup: RST_SETUP, command: RST_COMMAND, recover: RST_RECOVER};
            end else if (cfg_we && (cfg_set == SET_W'(s))) begin
                case (cfg_phase)
                    2'd0:    sets[s].setup   <= cfg_wdata;
                    2'd1:    sets[s].command <= cfg_wdata;
                    2'd2:    sets[s].recover <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        lens.setup_len = phase_len(sets[rd_set].setup,   LEN_ONE);
        lens.cmd_len   = phase_len(sets[rd_set].command, CMD_FLOOR);
        lens.rec_len   = phase_len(sets[rd_set].recover, LEN_ONE);
    end

endmodule

// File: rtl/cbt_phase_seq.sv
module cbt_phase_seq
    import cbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  phase_lens_t lens,
    output phase_e      phase,
    output logic        last_cycle,
    output logic        done
);

    phase_lens_t      held;
    logic [LEN_W-1:0] cnt;

    assign last_cycle = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            held  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        held  <= lens;
                        cnt   <= lens.setup_len - LEN_ONE;
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last_cycle) begin
                        cnt   <= held.cmd_len - LEN_ONE;
                        phase <= PH_CMD;
                    end else begin
                        cnt <= cnt - LEN_ONE;
                    end
                end
                PH_CMD: begin
                    if (last_cycle) begin
                        cnt   <= held.rec_len - LEN_ONE;
                        phase <= PH_REC;
                    end else begin
                        cnt <= cnt - LEN_ONE;
                    end
                end
                PH_REC: begin
                    if (last_cycle) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - LEN_ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_CMD_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_CMD) |-> ($past(phase) == PH_SETUP)); // R1

    AST_REC_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_REC) |-> ($past(phase) == PH_CMD)); // R1

    AST_CMD_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_CMD) |-> (cnt != '0)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_REC: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_REC) && (phase == PH_IDLE)); // R10

endmodule

// File: rtl/cbt_lane_steer.sv
module cbt_lane_steer
    import cbt_pkg::*;
(
    input  logic              host8,
    input  logic              odd,
    input  logic [DATA_W-1:0] host_wr,
    input  logic [DATA_W-1:0] card_rd,
    output logic [DATA_W-1:0] card_wr,
    output logic [DATA_W-1:0] host_rd
);

    always_comb begin
        if (host8) begin
            card_wr = {{BYTE_W{1'b0}}, odd ? host_wr[DATA_W-1:BYTE_W] : host_wr[BYTE_W-1:0]};
            host_rd = odd ? {card_rd[BYTE_W-1:0], {BYTE_W{1'b0}}}
                          : {{BYTE_W{1'b0}}, card_rd[BYTE_W-1:0]};
        end else begin
            card_wr = host_wr;
            host_rd = card_rd;
        end
    end

endmodule

// File: rtl/card_cycle_timer.sv
module card_cycle_timer
    import cbt_pkg::*;
#(
    parameter int AW       = 26,
    parameter int NUM_SETS = 2,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host8,
    input  logic              cfg_we,
    input  logic [SET_W-1:0]  cfg_set,
    input  logic [1:0]        cfg_phase,
    input  logic [7:0]        cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_regspace,
    input  logic [15:0]       req_wdata,
    input  logic [SET_W-1:0]  req_timer_sel,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic [AW-1:0]     card_addr,
    output logic              card_reg_n,
    output logic              card_ce1_n,
    output logic              card_ce2_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic              card_iord_n,
    output logic              card_iowr_n,
    output logic [15:0]       card_d_out,
    output logic              card_d_oe,
    input  logic [15:0]       card_d_in
);

    phase_lens_t       lens;
    phase_e            phase;
    logic              last_cycle;
    logic              accept;
    req_info_t         cur;
    logic [AW-1:0]     cur_addr;
    logic [DATA_W-1:0] steer_wr;
    logic [DATA_W-1:0] steer_rd;
    logic              active;
    logic              strobe_on;
    logic              is_wr;

    assign accept = req_valid && (phase == PH_IDLE);

    cbt_timing_regs #(.NUM_SETS(NUM_SETS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_set   (cfg_set),
        .cfg_phase (cfg_phase),
        .cfg_wdata (cfg_wdata),
        .rd_set    (req_timer_sel),
        .lens      (lens)
    );

    cbt_phase_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .lens       (lens),
        .phase      (phase),
        .last_cycle (last_cycle),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '{kind: K_MEM_RD, regspace: 1'b0, host8: 1'b0, wdata: '0};
            cur_addr <= '0;
        end else if (accept) begin
            cur.kind     <= kind_e'(req_kind);
            cur.regspace <= req_regspace;
            cur.host8    <= host8;
            cur.wdata    <= req_wdata;
            cur_addr     <= req_addr;
        end
    end

    cbt_lane_steer i_steer (
        .host8   (cur.host8),
        .odd     (cur_addr[0]),
        .host_wr (cur.wdata),
        .card_rd (card_d_in),
        .card_wr (steer_wr),
        .host_rd (steer_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if ((phase == PH_CMD) && last_cycle && !kind_is_write(cur.kind)) begin
            rd_data <= steer_rd;
        end
    end

    assign active    = (phase != PH_IDLE);
    assign strobe_on = (phase == PH_CMD);
    assign is_wr     = kind_is_write(cur.kind);

    assign busy        = active;
    assign card_addr   = active ? cur_addr : '0;
    assign card_reg_n  = !(active && (kind_is_io(cur.kind) || cur.regspace));
    assign card_ce1_n  = !active;
    assign card_ce2_n  = !active || cur.host8;
    assign card_oe_n   = !(strobe_on && (cur.kind == K_MEM_RD));
    assign card_we_n   = !(strobe_on && (cur.kind == K_MEM_WR));
    assign card_iord_n = !(strobe_on && (cur.kind == K_IO_RD));
    assign card_iowr_n = !(strobe_on && (cur.kind == K_IO_WR));
    assign card_d_oe   = active && is_wr;
    assign card_d_out  = card_d_oe ? steer_wr : '0;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}) <= 1); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(card_addr)); // R1

    AST_WDATA_UNDER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!card_we_n || !card_iowr_n) |-> (card_d_oe && $past(card_d_oe))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (card_oe_n && card_we_n && card_iord_n && card_iowr_n &&
                   card_ce1_n && card_ce2_n && card_reg_n && !card_d_oe)); // R11

    AST_RD_HOLD_OUTSIDE_CMD: assert property (@(posedge clk) disable iff (rst)
        ($past(card_oe_n) && $past(card_iord_n)) |-> $stable(rd_data)); // R7

endmodule

// File: tb/test_card_cycle_timer.sv
module test_card_cycle_timer;

    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host8 = 1'b0;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_set = '0;
    logic [1:0]    cfg_phase = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_regspace = 1'b0;
    logic [15:0]   req_wdata = '0;
    logic [0:0]    req_timer_sel = '0;
    logic          busy, done;
    logic [15:0]   rd_data;
    logic [AW-1:0] card_addr;
    logic          card_reg_n, card_ce1_n, card_ce2_n;
    logic          card_oe_n, card_we_n, card_iord_n, card_iowr_n;
    logic [15:0]   card_d_out;
    logic          card_d_oe;
    logic [15:0]   card_d_in;

    always #2 clk = ~clk;

    card_cycle_timer #(.AW(AW), .NUM_SETS(2)) i_card_cycle_timer (
        .clk(clk), .rst(rst), .host8(host8),
        .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_phase(cfg_phase), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_regspace(req_regspace), .req_wdata(req_wdata), .req_timer_sel(req_timer_sel),
        .busy(busy), .done(done), .rd_data(rd_data),
        .card_addr(card_addr), .card_reg_n(card_reg_n),
        .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n),
        .card_oe_n(card_oe_n), .card_we_n(card_we_n),
        .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n),
        .card_d_out(card_d_out), .card_d_oe(card_d_oe), .card_d_in(card_d_in)
    );

    function automatic logic [7:0] card_byte(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // Card model: 8-bit access puts the addressed byte on the low lane, junk above.
    assign card_d_in = card_ce2_n ? {8'hEE, card_byte(card_addr)}
                                  : {card_byte(card_addr | 1), card_byte(card_addr & ~AW'(1))};

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct {
        int            s_len, c_len, r_len;
        logic [3:0]    mask;
        logic          wr;
        logic          reg_n;
        logic          ce2_n;
        logic [AW-1:0] addr;
        logic [15:0]   dout;
        logic [15:0]   rd;
    } exp_t;

    exp_t q[$];
    logic [7:0] shadow [2][3];

    function automatic int blen(input logic [7:0] v, input int floor_len);
        int p, n;
        p = (v[7:6] != 2'b00) ? 16 : 1;
        n = p * int'(v[5:0]) + 1;
        return (n < floor_len) ? floor_len : n;
    endfunction

    task automatic wreg(input int set, input int ph, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_set = 1'(set); cfg_phase = 2'(ph); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[set][ph] = val;
    endtask

    // Driver: push expected item, issue request, wait for completion.
    task automatic access(input int kind, input logic [AW-1:0] addr, input logic regsp,
                          input logic [15:0] wdata, input int set, input logic h8,
                          input bit nudge, input bit mid_write);
        exp_t e;
        logic odd;
        odd = addr[0];
        e.s_len = blen(shadow[set][0], 1);
        e.c_len = blen(shadow[set][1], 2);
        e.r_len = blen(shadow[set][2], 1);
        e.mask  = 4'b0001 << kind;
        e.wr    = (kind == 1) || (kind == 3);
        e.reg_n = (kind >= 2) ? 1'b0 : !regsp;
        e.ce2_n = h8;
        e.addr  = addr;
        if (h8) begin
            e.dout = {8'h00, odd ? wdata[15:8] : wdata[7:0]};
            e.rd   = odd ? {card_byte(addr), 8'h00} : {8'h00, card_byte(addr)};
        end else begin
            e.dout = wdata;
            e.rd   = {card_byte(addr | 1), card_byte(addr & ~AW'(1))};
        end
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_addr = addr; req_regspace = regsp;
        req_wdata = wdata; req_timer_sel = 1'(set); host8 = h8;
        @(negedge clk);
        req_valid = 1'b0;
        if (nudge) begin
            // R10: a request while busy must not start anything
            req_valid = 1'b1; req_kind = 2'd3; req_addr = '1; req_timer_sel = 1'(1 - set);
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (mid_write) begin
            // R5: change the running set mid-access; must only affect later accesses
            cfg_we = 1'b1; cfg_set = 1'(set); cfg_phase = 2'd1; cfg_wdata = 8'h0A;
            @(negedge clk);
            cfg_we = 1'b0;
            shadow[set][1] = 8'h0A;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    int m_s = 0, m_c = 0, m_r = 0;
    bit m_saw = 0, m_oe_bad = 0, m_addr_bad = 0, m_dout_bad = 0;
    logic [3:0] m_mask = '0;
    logic m_regn = 1'b1, m_ce2 = 1'b1, m_ce1 = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && q.size() > 0) begin
                logic [3:0] act;
                act = {!card_iowr_n, !card_iord_n, !card_we_n, !card_oe_n};
                if (act != 4'b0000) begin
                    m_c++; m_saw = 1; m_mask |= act;
                    m_regn = card_reg_n; m_ce2 = card_ce2_n; m_ce1 = card_ce1_n;
                    if (q[0].wr && card_d_out !== q[0].dout) m_dout_bad = 1;
                end else if (m_saw) m_r++;
                else m_s++;
                if (card_d_oe !== q[0].wr) m_oe_bad = 1;
                if (q[0].wr && card_d_oe && card_d_out !== q[0].dout) m_dout_bad = 1;
                if (card_addr !== q[0].addr) m_addr_bad = 1;
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(m_s == e.s_len, "R2 setup cycles", m_s, e.s_len);
                    chk(m_c == e.c_len, "R2 command cycles", m_c, e.c_len);
                    chk(m_r == e.r_len, "R2 recovery cycles", m_r, e.r_len);
                    chk(m_mask == e.mask, "R8 strobe used", m_mask, e.mask);
                    chk(!m_addr_bad, "R1 address held", m_addr_bad, 0);
                    chk(!m_oe_bad, "R6 data enable", m_oe_bad, 0);
                    chk(m_regn == e.reg_n, "R12 reg line", m_regn, e.reg_n);
                    chk(m_ce2 == e.ce2_n && !m_ce1, "R9 card enables", {m_ce2, m_ce1}, {e.ce2_n, 1'b0});
                    if (e.wr) chk(!m_dout_bad, "R9 write lane", m_dout_bad, 0);
                    else chk(rd_data == e.rd, "R7 read capture", rd_data, e.rd);
                    chk(!busy, "R10 idle at done", busy, 0);
                end
                m_s = 0; m_c = 0; m_r = 0; m_saw = 0; m_mask = '0;
                m_oe_bad = 0; m_addr_bad = 0; m_dout_bad = 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            shadow[s][0] = 8'h01; shadow[s][1] = 8'h06; shadow[s][2] = 8'h03;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !done, "R11 busy/done after reset", {busy, done}, 0);
        chk({card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n, card_reg_n} == 7'h7F,
            "R11 strobes idle", {card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n, card_reg_n}, 7'h7F);
        chk(!card_d_oe && rd_data == 16'h0, "R11 data idle", {card_d_oe, rd_data}, 0);

        // R3: defaults of both sets (2/7/4)
        access(0, 26'h0001230, 1'b0, 16'h0000, 0, 1'b0, 0, 0);
        access(1, 26'h0004560, 1'b0, 16'hBEEF, 1, 1'b0, 0, 0);
        // R8, R12: I/O and attribute accesses
        access(2, 26'h0000300, 1'b0, 16'h0000, 0, 1'b0, 0, 0);
        access(3, 26'h0000302, 1'b1, 16'h1357, 1, 1'b0, 0, 0);
        access(0, 26'h0000040, 1'b1, 16'h0000, 0, 1'b0, 0, 0);
        // R9: 8-bit host, even and odd bytes
        access(1, 26'h0000010, 1'b0, 16'hA1B2, 0, 1'b1, 0, 0);
        access(1, 26'h0000011, 1'b0, 16'hA1B2, 0, 1'b1, 0, 0);
        access(0, 26'h0000022, 1'b0, 16'h0000, 1, 1'b1, 0, 0);
        access(2, 26'h0000023, 1'b0, 16'h0000, 1, 1'b1, 0, 0);
        // R4: command clamp for values 00h and 01h
        wreg(1, 1, 8'h00);
        access(0, 26'h0000100, 1'b0, 16'h0000, 1, 1'b0, 0, 0);
        wreg(1, 1, 8'h01);
        access(1, 26'h0000102, 1'b0, 16'h4242, 1, 1'b0, 0, 0);
        // R2: prescale 16 through each top-bit pattern
        wreg(1, 0, 8'h42);
        wreg(1, 1, 8'h81);
        wreg(1, 2, 8'hC0);
        access(3, 26'h0000200, 1'b0, 16'h9876, 1, 1'b0, 0, 0);
        // R5: write during an access applies to the next one only
        access(0, 26'h0000400, 1'b0, 16'h0000, 0, 1'b0, 0, 1);
        access(0, 26'h0000402, 1'b0, 16'h0000, 0, 1'b0, 0, 0);
        // R10: requests while busy ignored
        access(2, 26'h0000500, 1'b0, 16'h0000, 0, 1'b0, 1, 0);
        repeat (4) begin
            @(negedge clk);
            chk(!busy && !done, "R10 no stray access", {busy, done}, 0);
        end
        // Random register values and accesses (R2, R5)
        for (int i = 0; i < 12; i++) begin
            int set, k;
            set = int'($urandom_range(0, 1));
            for (int ph = 0; ph < 3; ph++) begin
                logic [7:0] v;
                v = 8'($urandom);
                if ($urandom_range(0, 3) != 0) v[7:6] = 2'b00;
                wreg(set, ph, v);
            end
            k = int'($urandom_range(0, 3));
            access(k, AW'($urandom), 1'($urandom), 16'($urandom), set, 1'($urandom), 0, 0);
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10 all accesses completed", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule